// File: doc/BRIEF.md
# Serial Port Pin Function Controller

This block decides, pin by pin, whether four bits of a shared 8-bit general-purpose port behave as ordinary port I/O or are claimed by a serial engine. The serial engine runs in either clock-synchronous or UART mode. The four claimed roles are transmit data, receive data, shift clock and an active-low receive-ready output. A single control register, written and read over a simple CPU bus, holds the serial enable, the mode, the clock source, the ready-output enable and the transmit enable. From these the block produces the output enable and output value of every port pin. It routes the receive-data pin and the external shift clock to the engine, and it generates the ready strobe.

Any pin that the serial function does not claim takes its direction and output level from the port's own direction and data registers. The shift-clock pin drives out in synchronous mode with the internal clock. It is an input whenever the external clock is selected. In UART mode with the internal clock it stays an ordinary port pin. The ready output drops low after the engine writes its data buffer. It rises again on transfer completion, or once either gating bit is cleared.

Top module: `ser_pin_ctrl`

## Requirements
- R1: The control register resets to 0x00. A write with bus_addr_i equal to CTRL_ADDR (default 0xA) stores bus_wdata_i at the clock edge. bus_rdata_o returns the stored value while bus_addr_i equals CTRL_ADDR and 0x00 otherwise. Writes to any other address leave the register unchanged. The control bits are: 7 serial enable, 6 mode (1 = UART, 0 = clock-synchronous), 4 transmit enable, 2 ready-output enable, 1 clock source (1 = external). Bits 5, 3 and 0 are stored and read back only.
- R2: With serial enable 0, all four serial pins (transmit on bit 5, receive on bit 4, shift clock on bit 6, ready on bit 7) take pin_oe_o from port_dir_i and pin_out_o from port_out_i.
- R3: With serial enable 1, pin 5 has pin_oe_o = 1 and pin_out_o = ser_txd_i.
- R4: With serial enable 1, pin 4 has pin_oe_o = 0 and pin_out_o = 0, and ser_rxd_o follows rxd_pad_i. With serial enable 0, ser_rxd_o is held at 1.
- R5: With serial enable 1, synchronous mode and the internal clock, pin 6 has pin_oe_o = 1 and pin_out_o = ser_clk_int_i.
- R6: With serial enable 1 and the external clock selected, in either mode, pin 6 has pin_oe_o = 0 and pin_out_o = 0, and ser_clk_ext_o follows sclk_pad_i. In every other case ser_clk_ext_o is 0.
- R7: With serial enable 1, UART mode and the internal clock, pin 6 behaves as a port pin.
- R8: Pin 7 drives the ready level (pin_oe_o = 1, pin_out_o = ready level) only when serial enable is 1, the mode is synchronous and the ready enable is 1. Otherwise it is a port pin. In UART mode it is always a port pin.
- R9: The ready level is 1 after reset. When serial enable, synchronous mode, ready enable and transmit enable are all set, a buf_wr_i pulse drives it to 0 from the next clock edge.
- R10: The ready level returns to 1 at the edge after an xfer_done_i pulse. If buf_wr_i arrives in the same cycle, buf_wr_i wins. The ready level is also 1 at the edge after any gating condition of R9 is cleared. A buf_wr_i pulse while the gating conditions do not all hold leaves it at 1.
- R11: Port bits 0 to 3 always follow port_dir_i and port_out_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data |
| port_dir_i | input | PORT_W | Port direction register (1 = output) |
| port_out_i | input | PORT_W | Port data register |
| rxd_pad_i | input | 1 | Level on the receive-data pin |
| sclk_pad_i | input | 1 | Level on the shift-clock pin |
| ser_txd_i | input | 1 | Transmit bit from the serial engine |
| ser_clk_int_i | input | 1 | Internal shift clock from the serial engine |
| buf_wr_i | input | 1 | Serial data buffer written strobe |
| xfer_done_i | input | 1 | Transfer complete strobe |
| pin_oe_o | output | PORT_W | Per-pin output enable |
| pin_out_o | output | PORT_W | Per-pin output level |
| ser_rxd_o | output | 1 | Receive data to the serial engine |
| ser_clk_ext_o | output | 1 | External shift clock to the serial engine |

## Verification
The bench writes all 256 control values and, for each, applies several port and pad patterns. It compares every pin against an arithmetic model. This catches a shift-clock pin that drives in UART mode, or that ignores the external-clock bit. It also catches a ready pin claimed in UART mode and a receive pin left driving. The ready sequences cover four cases. A buffer write and a completion in the same cycle must leave the level low. Clearing transmit enable must raise the level one edge after the write lands, not at the write itself. A buffer write with a gating bit clear must not disturb the high level. A write to the wrong address must not alter the register.

// File: rtl/ser_pin_pkg.sv
package ser_pin_pkg;

  typedef struct packed {
    logic ser_en;     // 7
    logic uart_mode;  // 6
    logic spare5;
    logic tx_en;      // 4
    logic spare3;
    logic rdy_en;     // 2
    logic ext_clk;    // 1
    logic spare0;
  } ser_ctrl_t;

  localparam int unsigned CTRL_W = $bits(ser_ctrl_t);

  typedef enum logic [1:0] {
    PIN_PORT  = 2'd0,
    PIN_DRIVE = 2'd1,
    PIN_SENSE = 2'd2
  } pin_role_e;

endpackage

// File: rtl/ser_ctrl_reg.sv
module ser_ctrl_reg
  import ser_pin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] rdata_o,
  output logic              ser_en_o,
  output logic              uart_o,
  output logic              tx_en_o,
  output logic              rdy_en_o,
  output logic              ext_clk_o
);

  ser_ctrl_t ctrl_q;
  logic      hit;

  assign hit = (addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_q <= '0;
    else if (we_i && hit) ctrl_q <= ser_ctrl_t'(wdata_i);
  end

  assign rdata_o   = hit ? CTRL_W'(ctrl_q) : '0;
  assign ser_en_o  = ctrl_q.ser_en;
  assign uart_o    = ctrl_q.uart_mode;
  assign tx_en_o   = ctrl_q.tx_en;
  assign rdy_en_o  = ctrl_q.rdy_en;
  assign ext_clk_o = ctrl_q.ext_clk;

  // R1
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit) |=> (CTRL_W'(ctrl_q) == $past(wdata_i)));

  // R1
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && hit) |=> $stable(ctrl_q));

endmodule

// File: rtl/ser_rdy_gen.sv
module ser_rdy_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic buf_wr_i,
  input  logic xfer_done_i,
  output logic rdy_n_o
);

  logic rdy_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rdy_n_q <= 1'b1;
    else if (!gate_i)     rdy_n_q <= 1'b1;
    else if (buf_wr_i)    rdy_n_q <= 1'b0;
    else if (xfer_done_i) rdy_n_q <= 1'b1;
  end

  assign rdy_n_o = rdy_n_q;

  // R9
  rdy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && buf_wr_i) |=> !rdy_n_q);

  // R10
  rdy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !buf_wr_i && xfer_done_i) |=> rdy_n_q);

  // R10
  rdy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> rdy_n_q);

endmodule

// File: rtl/ser_pin_route.sv
module ser_pin_route
  import ser_pin_pkg::*;
#(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned TXD_BIT  = 5,
  parameter int unsigned RXD_BIT  = 4,
  parameter int unsigned SCLK_BIT = 6,
  parameter int unsigned RDY_BIT  = 7
) (
  input  logic              ser_en_i,
  input  logic              uart_i,
  input  logic              rdy_en_i,
  input  logic              ext_clk_i,
  input  logic [PORT_W-1:0] port_dir_i,
  input  logic [PORT_W-1:0] port_out_i,
  input  logic              rxd_pad_i,
  input  logic              sclk_pad_i,
  input  logic              ser_txd_i,
  input  logic              ser_clk_int_i,
  input  logic              rdy_n_i,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] pin_out_o,
  output logic              ser_rxd_o,
  output logic              ser_clk_ext_o
);

  pin_role_e         role [PORT_W];
  logic [PORT_W-1:0] drv;

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i == TXD_BIT) begin : g_txd
      assign role[i] = ser_en_i ? PIN_DRIVE : PIN_PORT;
      assign drv[i]  = ser_txd_i;
    end else if (i == RXD_BIT) begin : g_rxd
      assign role[i] = ser_en_i ? PIN_SENSE : PIN_PORT;
      assign drv[i]  = 1'b0;
    end else if (i == SCLK_BIT) begin : g_sclk
      // external clock is an input in both modes; internal drives only when synchronous
      assign role[i] = !ser_en_i ? PIN_PORT  :
                       ext_clk_i ? PIN_SENSE :
                       !uart_i   ? PIN_DRIVE : PIN_PORT;
      assign drv[i]  = ser_clk_int_i;
    end else if (i == RDY_BIT) begin : g_rdy
      assign role[i] = (ser_en_i && !uart_i && rdy_en_i) ? PIN_DRIVE : PIN_PORT;
      assign drv[i]  = rdy_n_i;
    end else begin : g_plain
      assign role[i] = PIN_PORT;
      assign drv[i]  = 1'b0;
    end

    always_comb begin
      unique case (role[i])
        PIN_DRIVE: begin pin_oe_o[i] = 1'b1; pin_out_o[i] = drv[i]; end
        PIN_SENSE: begin pin_oe_o[i] = 1'b0; pin_out_o[i] = 1'b0;   end
        default:   begin pin_oe_o[i] = port_dir_i[i]; pin_out_o[i] = port_out_i[i]; end
      endcase
    end
  end

  assign ser_rxd_o     = ser_en_i ? rxd_pad_i : 1'b1;
  assign ser_clk_ext_o = (ser_en_i && ext_clk_i) ? sclk_pad_i : 1'b0;

endmodule

// File: rtl/ser_pin_ctrl.sv
module ser_pin_ctrl
  import ser_pin_pkg::*;
#(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hA,
  parameter int unsigned TXD_BIT  = 5,
  parameter int unsigned RXD_BIT  = 4,
  parameter int unsigned SCLK_BIT = 6,
  parameter int unsigned RDY_BIT  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic [PORT_W-1:0] port_dir_i,
  input  logic [PORT_W-1:0] port_out_i,
  input  logic              rxd_pad_i,
  input  logic              sclk_pad_i,
  input  logic              ser_txd_i,
  input  logic              ser_clk_int_i,
  input  logic              buf_wr_i,
  input  logic              xfer_done_i,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] pin_out_o,
  output logic              ser_rxd_o,
  output logic              ser_clk_ext_o
);

  logic ser_en, uart, tx_en, rdy_en, ext_clk;
  logic rdy_gate, rdy_n;

  ser_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .ser_en_o  (ser_en),
    .uart_o    (uart),
    .tx_en_o   (tx_en),
    .rdy_en_o  (rdy_en),
    .ext_clk_o (ext_clk)
  );

  assign rdy_gate = ser_en && !uart && rdy_en && tx_en;

  ser_rdy_gen u_rdy (
    .clk_i, .rst_ni,
    .gate_i      (rdy_gate),
    .buf_wr_i,
    .xfer_done_i,
    .rdy_n_o     (rdy_n)
  );

  ser_pin_route #(
    .PORT_W(PORT_W), .TXD_BIT(TXD_BIT), .RXD_BIT(RXD_BIT),
    .SCLK_BIT(SCLK_BIT), .RDY_BIT(RDY_BIT)
  ) u_route (
    .ser_en_i  (ser_en),
    .uart_i    (uart),
    .rdy_en_i  (rdy_en),
    .ext_clk_i (ext_clk),
    .port_dir_i, .port_out_i,
    .rxd_pad_i, .sclk_pad_i,
    .ser_txd_i, .ser_clk_int_i,
    .rdy_n_i   (rdy_n),
    .pin_oe_o, .pin_out_o,
    .ser_rxd_o, .ser_clk_ext_o
  );

  // R5
  sclk_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en && !uart && !ext_clk) |-> (pin_oe_o[SCLK_BIT] && pin_out_o[SCLK_BIT] == ser_clk_int_i));

  // R7
  sclk_uart_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart && !ext_clk) |-> (pin_oe_o[SCLK_BIT] == port_dir_i[SCLK_BIT]));

  // R6
  sclk_sense_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en && ext_clk) |-> (!pin_oe_o[SCLK_BIT] && ser_clk_ext_o == sclk_pad_i));

  // R8
  rdy_uart_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uart |-> (pin_oe_o[RDY_BIT] == port_dir_i[RDY_BIT] && pin_out_o[RDY_BIT] == port_out_i[RDY_BIT]));

  // R4
  rxd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en |-> ser_rxd_o);

endmodule

// File: tb/ser_pin_ctrl_test.sv
module ser_pin_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pdir = 8'h00, pout = 8'h00;
  logic       rxd_pad = 1'b0, sclk_pad = 1'b0, txd = 1'b0, clk_int = 1'b0;
  logic       buf_wr = 1'b0, done = 1'b0;
  logic [7:0] oe, out;
  logic       rxd, clk_ext;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ser_pin_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .port_dir_i(pdir), .port_out_i(pout),
    .rxd_pad_i(rxd_pad), .sclk_pad_i(sclk_pad),
    .ser_txd_i(txd), .ser_clk_int_i(clk_int),
    .buf_wr_i(buf_wr), .xfer_done_i(done),
    .pin_oe_o(oe), .pin_out_o(out),
    .ser_rxd_o(rxd), .ser_clk_ext_o(clk_ext)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 4'hA;
  endtask

  task automatic pulse(input bit w, input bit d);
    @(negedge clk); buf_wr = w; done = d;
    @(negedge clk); buf_wr = 1'b0; done = 1'b0;
  endtask

  // model of the pin map for a control value, ready level fixed at rdy
  function automatic logic [7:0] exp_oe(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = d;
    if (c[7]) begin
      r[5] = 1'b1; r[4] = 1'b0;
      if (c[1]) r[6] = 1'b0; else if (!c[6]) r[6] = 1'b1;
      if (!c[6] && c[2]) r[7] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_out(input logic [7:0] c, input logic [7:0] p,
                                         input logic t, input logic k, input logic rdy);
    logic [7:0] r = p;
    if (c[7]) begin
      r[5] = t; r[4] = 1'b0;
      if (c[1]) r[6] = 1'b0; else if (!c[6]) r[6] = k;
      if (!c[6] && c[2]) r[7] = rdy;
    end
    return r;
  endfunction

  initial begin
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    addr = 4'hA;
    #13 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R9 idle high, R2 port ownership after reset
    check("R1 reset", rdata, 8'h00);
    check("R9 reset ready", {7'd0, out[7]}, {7'd0, 1'b0} | {7'd0, pout[7]});
    check("R2 reset oe", oe, pdir);

    // R1 write to other address ignored, other-address read returns 0
    bus_write(4'h3, 8'h5C);
    check("R1 wrong addr", rdata, 8'h00);
    bus_write(4'hA, 8'h29);
    addr = 4'h2; #1;
    check("R1 other read", rdata, 8'h00);
    addr = 4'hA; #1;
    check("R1 readback", rdata, 8'h29);

    // R2 R3 R4 R5 R6 R7 R8 R11 exhaustive control sweep
    for (int c = 0; c < 256; c++) begin
      bus_write(4'hA, 8'(c));
      check("R1 sweep readback", rdata, 8'(c));
      for (int p = 0; p < 4; p++) begin
        pdir = pats[p]; pout = ~pats[(p + 1) % 4];
        txd = p[0]; clk_int = p[1]; rxd_pad = ~p[0]; sclk_pad = p[1] ^ p[0];
        #1;
        check("R2/R3/R5/R7/R8/R11 oe", oe, exp_oe(8'(c), pdir));
        check("R2/R3/R5/R7/R8/R11 out", out, exp_out(8'(c), pout, txd, clk_int, 1'b1));
        check("R4 rxd", {7'd0, rxd}, {7'd0, c[7] ? rxd_pad : 1'b1});
        check("R6 clk_ext", {7'd0, clk_ext}, {7'd0, (c[7] && c[1]) ? sclk_pad : 1'b0});
      end
    end
    pdir = 8'h00; pout = 8'h00;

    // R9 fall after buffer write with all gates set (0x94: en, tx_en, rdy_en, sync)
    bus_write(4'hA, 8'h94);
    @(negedge clk);
    check("R9 idle high", {oe[7], out[7]}, 2'b11);
    pulse(1'b1, 1'b0);
    check("R9 fall", {oe[7], out[7]}, 2'b10);
    pulse(1'b0, 1'b1);
    check("R10 done rise", {oe[7], out[7]}, 2'b11);
    pulse(1'b1, 1'b1);
    check("R10 buf_wr wins", {oe[7], out[7]}, 2'b10);
    // R10 clearing tx_en: edge that writes still sees old gate
    bus_write(4'hA, 8'h84);
    check("R10 gate drop same edge", out[7], 1'b0);
    @(negedge clk);
    check("R10 gate drop next edge", out[7], 1'b1);
    pulse(1'b1, 1'b0);
    check("R10 wr ignored no tx_en", out[7], 1'b1);
    // R8 ready enable clear releases pin to port
    bus_write(4'hA, 8'h90);
    pulse(1'b1, 1'b0);
    check("R8 port when rdy_en clear", {oe[7], out[7]}, 2'b00);
    // R8 R10 UART mode with all gates: pin is port, no fall
    pdir = 8'h80; pout = 8'h80;
    bus_write(4'hA, 8'hD4);
    pulse(1'b1, 1'b0);
    check("R8 uart rdy port", {oe[7], out[7]}, 2'b11);
    bus_write(4'hA, 8'h94);
    @(negedge clk);
    check("R10 uart wr left high", {oe[7], out[7]}, 2'b11);
    pulse(1'b1, 1'b0);
    // R10 serial enable clear
    bus_write(4'hA, 8'h14);
    @(negedge clk);
    bus_write(4'hA, 8'h94);
    check("R10 en drop rise", out[7], 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule